// File: doc/BRIEF.md
# Triangle Primitive Assembler

The assembler receives a stream of vertex identifiers, one word per accepted transfer, and groups them into triangles. Each triangle is three identifier words presented together under a valid/ready handshake. Three groupings are supported: independent triples (list), strips that share an edge with the previous triangle, and fans that share a common first vertex. A fourth configuration code, meant for shader-driven setup, groups vertices exactly like list mode. The block carries no vertex attributes. It only buffers two identifiers and picks which ones form each triangle.

A one-cycle configuration strobe loads a new topology code and clears any partly assembled primitive. A one-cycle restart strobe clears the partial primitive and keeps the current topology. While a finished triangle waits for the consumer, the input is stalled, so no vertex is lost.

Top module: `tri_assembler`

## Requirements
- R1: After reset the topology is list (code 0), `outValid` is low and `inReady` is high.
- R2: In list mode (code 0), each run of three accepted vertices a, b, c yields one triangle (a, b, c), and the next vertex starts a new group. The triangle appears on the outputs in the cycle after the third vertex is accepted.
- R3: Topology code 3 yields exactly the same triangles as list mode.
- R4: In strip mode (code 1), the first two vertices yield nothing. Each later vertex v yields (slot0, slot1, v) and then overwrites the slot chosen by a write index that alternates 0,1,0,1. Vertices v0..v4 therefore yield (v0,v1,v2), (v2,v1,v3) and (v2,v3,v4).
- R5: In fan mode (code 2), the write index is held at 1 after every vertex, so the first vertex stays as the centre. Vertices v0..v4 yield (v0,v1,v2), (v0,v2,v3) and (v0,v3,v4).
- R6: In strip and fan modes, once a vertex has been written into slot 1, every further accepted vertex yields a triangle until the next clear.
- R7: A configuration strobe loads `cfgTopo` and discards any partly assembled primitive. Vertices accepted afterwards are grouped from scratch in the new mode.
- R8: A restart strobe discards the partly assembled primitive and leaves the topology unchanged.
- R9: While `outValid` is high and `outReady` is low, `inReady` is low and the three output words hold steady.
- R10: In any cycle where the configuration or restart strobe is high, `inReady` is low, so no vertex is accepted during a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Load topology strobe |
| cfgTopo | input | 2 | Topology code: 0 list, 1 strip, 2 fan, 3 shader setup |
| restart | input | 1 | Clear partial primitive, keep topology |
| inValid | input | 1 | Vertex word valid |
| inVertex | input | VTX_W | Vertex identifier |
| inReady | output | 1 | Vertex accepted when high together with inValid |
| outValid | output | 1 | Triangle valid |
| outV0 | output | VTX_W | First triangle vertex |
| outV1 | output | VTX_W | Second triangle vertex |
| outV2 | output | VTX_W | Third triangle vertex |
| outReady | input | 1 | Consumer takes the triangle |

## Verification
The hardest cases to reach are the clears that land in the middle of a primitive: a restart after a fan has already rotated its second slot, and a topology reload after a strip has set its ready flag. The bench builds up such a partial state with directed vertex sequences, fires the strobe, and then sends just enough vertices to show whether the old slots or the old ready flag survived. Backpressure is reached by holding the consumer off while a triangle completes, then offering one more vertex.

// File: rtl/tri_asm_pkg.sv
package tri_asm_pkg;
  typedef enum logic [1:0] {
    TOPO_LIST   = 2'd0,
    TOPO_STRIP  = 2'd1,
    TOPO_FAN    = 2'd2,
    TOPO_SHADER = 2'd3
  } topo_e;

  localparam int SLOTS = 2;

  typedef struct packed {
    logic [SLOTS-1:0] load;
    logic             emit;
  } asmStrobes_t;
endpackage

// File: rtl/tri_asm_ctrl.sv
module tri_asm_ctrl
  import tri_asm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgValid,
  input  logic [1:0]  cfgTopo,
  input  logic        restart,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output asmStrobes_t strobes
);
  localparam int IDX_W = $clog2(SLOTS + 1);

  topo_e            topo;
  logic [IDX_W-1:0] wrIdx, wrIdxNxt;
  logic             primed, primedNxt;
  logic             accept, listMode, clearReq;

  assign clearReq = cfgValid | restart;
  assign inReady  = !outValid && !clearReq;
  assign accept   = inValid && inReady;
  assign listMode = (topo == TOPO_LIST) || (topo == TOPO_SHADER);

  always_comb begin
    strobes   = '0;
    wrIdxNxt  = wrIdx;
    primedNxt = primed;
    if (accept) begin
      for (int s = 0; s < SLOTS; s++)
        strobes.load[s] = (wrIdx == IDX_W'(s));
      if (listMode) begin
        strobes.emit = (wrIdx == IDX_W'(SLOTS));
        wrIdxNxt     = strobes.emit ? '0 : wrIdx + 1'b1;
      end else begin
        strobes.emit = primed;
        primedNxt    = primed | (wrIdx == IDX_W'(1));
        if (topo == TOPO_STRIP)
          wrIdxNxt = {{(IDX_W-1){1'b0}}, ~wrIdx[0]};
        else
          wrIdxNxt = IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topo     <= TOPO_LIST;
      wrIdx    <= '0;
      primed   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (cfgValid) topo <= topo_e'(cfgTopo);
      if (clearReq) begin
        wrIdx  <= '0;
        primed <= 1'b0;
      end else begin
        wrIdx  <= wrIdxNxt;
        primed <= primedNxt;
      end
      if (strobes.emit)  outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
    end
  end

  assert_reset_list_R1: assert property (@(posedge clk)
    !rstN |=> (topo == TOPO_LIST) && !outValid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  assert_strip_toggle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && topo == TOPO_STRIP) |=> (wrIdx != $past(wrIdx)));

  assert_fan_centre_R5: assert property (@(posedge clk) disable iff (!rstN)
    (primed && topo == TOPO_FAN) |-> (wrIdx == IDX_W'(1)));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !clearReq) |=> primed);

  assert_cfg_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> (topo == topo_e'($past(cfgTopo))) && !primed && (wrIdx == '0));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (restart && !cfgValid) |=> (topo == $past(topo)) && !primed && (wrIdx == '0));

  assert_no_take_R10: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |-> !strobes.emit && (strobes.load == '0));
endmodule

// File: rtl/tri_asm_datapath.sv
module tri_asm_datapath
  import tri_asm_pkg::*;
#(
  parameter int VTX_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  asmStrobes_t      strobes,
  input  logic [VTX_W-1:0] inVertex,
  output logic [VTX_W-1:0] outV0,
  output logic [VTX_W-1:0] outV1,
  output logic [VTX_W-1:0] outV2
);
  logic [VTX_W-1:0] slot [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)                slot[s] <= '0;
      else if (strobes.load[s]) slot[s] <= inVertex;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outV0 <= '0;
      outV1 <= '0;
      outV2 <= '0;
    end else if (strobes.emit) begin
      outV0 <= slot[0];
      outV1 <= slot[1];
      outV2 <= inVertex;
    end
  end

  assert_out_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.emit |=> $stable(outV0) && $stable(outV1) && $stable(outV2));
endmodule

// File: rtl/tri_assembler.sv
module tri_assembler
  import tri_asm_pkg::*;
#(
  parameter int VTX_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgValid,
  input  logic [1:0]       cfgTopo,
  input  logic             restart,
  input  logic             inValid,
  input  logic [VTX_W-1:0] inVertex,
  output logic             inReady,
  output logic             outValid,
  output logic [VTX_W-1:0] outV0,
  output logic [VTX_W-1:0] outV1,
  output logic [VTX_W-1:0] outV2,
  input  logic             outReady
);
  asmStrobes_t strobes;

  tri_asm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgTopo(cfgTopo),
    .restart(restart), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobes(strobes)
  );

  tri_asm_datapath #(.VTX_W(VTX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inVertex(inVertex),
    .outV0(outV0), .outV1(outV1), .outV2(outV2)
  );
endmodule

// File: tb/tri_assembler_tb.sv
module tri_assembler_tb_top;
  localparam int VW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgValid = 1'b0;
  logic [1:0] cfgTopo = 2'd0;
  logic restart = 1'b0;
  logic inValid = 1'b0;
  logic [VW-1:0] inVertex = '0;
  logic inReady, outValid, outReady;
  logic [VW-1:0] outV0, outV1, outV2;

  int total = 0;
  int bad = 0;
  int capN = 0;
  logic [3*VW-1:0] cap [64];
  bit finished = 0;

  always #5 clk = ~clk;

  tri_assembler #(.VTX_W(VW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgTopo(cfgTopo),
    .restart(restart), .inValid(inValid), .inVertex(inVertex),
    .inReady(inReady), .outValid(outValid), .outV0(outV0), .outV1(outV1),
    .outV2(outV2), .outReady(outReady)
  );

  always @(negedge clk)
    if (rstN && outValid && outReady && capN < 64) begin
      cap[capN] = {outV0, outV1, outV2};
      capN++;
    end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expTri(string req, int idx, int a, int b, int c);
    check({req, " count"}, 64'(capN > idx), 64'd1);
    if (capN > idx)
      check({req, " triangle"}, 64'(cap[idx]), 64'({VW'(a), VW'(b), VW'(c)}));
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic sendVtx(int v);
    @(posedge clk); #1;
    inValid  = 1'b1;
    inVertex = VW'(v);
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic setTopo(int t);
    @(posedge clk); #1;
    cfgValid = 1'b1;
    cfgTopo  = 2'(t);
    @(posedge clk); #1;
    cfgValid = 1'b0;
  endtask

  task automatic pulseRestart();
    @(posedge clk); #1;
    restart = 1'b1;
    @(posedge clk); #1;
    restart = 1'b0;
  endtask

  task automatic testReset();
    int base;
    @(negedge clk);
    check("R1 inReady", 64'(inReady), 64'd1);
    check("R1 outValid", 64'(outValid), 64'd0);
    base = capN;
    sendVtx(16'h11); sendVtx(16'h12); sendVtx(16'h13);
    settle();
    check("R1 default list count", 64'(capN - base), 64'd1);
    expTri("R1 default list", base, 16'h11, 16'h12, 16'h13);
  endtask

  task automatic testList(int code, string req);
    int base;
    setTopo(code);
    base = capN;
    for (int i = 0; i < 6; i++) sendVtx(16'h100 + i);
    settle();
    check({req, " tri count"}, 64'(capN - base), 64'd2);
    expTri(req, base, 16'h100, 16'h101, 16'h102);
    expTri(req, base + 1, 16'h103, 16'h104, 16'h105);
  endtask

  task automatic testStrip();
    int base;
    setTopo(1);
    base = capN;
    sendVtx(16'h200); sendVtx(16'h201);
    settle();
    check("R4 no tri from two", 64'(capN - base), 64'd0);
    for (int i = 2; i < 5; i++) sendVtx(16'h200 + i);
    settle();
    check("R6 strip tri count", 64'(capN - base), 64'd3);
    expTri("R4", base, 16'h200, 16'h201, 16'h202);
    expTri("R4", base + 1, 16'h202, 16'h201, 16'h203);
    expTri("R4", base + 2, 16'h202, 16'h203, 16'h204);
  endtask

  task automatic testFan();
    int base;
    setTopo(2);
    base = capN;
    for (int i = 0; i < 5; i++) sendVtx(16'h300 + i);
    settle();
    check("R6 fan tri count", 64'(capN - base), 64'd3);
    expTri("R5", base, 16'h300, 16'h301, 16'h302);
    expTri("R5", base + 1, 16'h300, 16'h302, 16'h303);
    expTri("R5", base + 2, 16'h300, 16'h303, 16'h304);
  endtask

  task automatic testCfgClear();
    int base;
    setTopo(0);
    base = capN;
    sendVtx(16'h400); sendVtx(16'h401);
    setTopo(0);
    sendVtx(16'h402); sendVtx(16'h403); sendVtx(16'h404);
    settle();
    check("R7 list partial dropped", 64'(capN - base), 64'd1);
    expTri("R7 list", base, 16'h402, 16'h403, 16'h404);
    setTopo(1);
    base = capN;
    sendVtx(16'h410); sendVtx(16'h411); sendVtx(16'h412);
    setTopo(1);
    sendVtx(16'h413);
    settle();
    check("R7 strip ready flag cleared", 64'(capN - base), 64'd1);
    sendVtx(16'h414); sendVtx(16'h415);
    settle();
    check("R7 strip regroup count", 64'(capN - base), 64'd2);
    expTri("R7 strip", base + 1, 16'h413, 16'h414, 16'h415);
  endtask

  task automatic testRestart();
    int base;
    setTopo(2);
    base = capN;
    sendVtx(16'h500); sendVtx(16'h501); sendVtx(16'h502);
    pulseRestart();
    sendVtx(16'h510); sendVtx(16'h511);
    settle();
    check("R8 restart clears flag", 64'(capN - base), 64'd1);
    sendVtx(16'h512); sendVtx(16'h513);
    settle();
    expTri("R8", base + 1, 16'h510, 16'h511, 16'h512);
    expTri("R8 fan kept", base + 2, 16'h510, 16'h512, 16'h513);
  endtask

  task automatic testBackpressure();
    int base;
    logic [3*VW-1:0] held;
    setTopo(0);
    @(posedge clk); #1;
    outReady = 1'b0;
    base = capN;
    sendVtx(16'h600); sendVtx(16'h601); sendVtx(16'h602);
    @(posedge clk); #1;
    inValid  = 1'b1;
    inVertex = 16'h603;
    @(negedge clk);
    check("R9 outValid held", 64'(outValid), 64'd1);
    check("R9 inReady low", 64'(inReady), 64'd0);
    held = {outV0, outV1, outV2};
    check("R9 held triangle", 64'(held), 64'({16'h600, 16'h601, 16'h602}));
    repeat (4) @(negedge clk);
    check("R9 stable", 64'({outV0, outV1, outV2}), 64'(held));
    check("R9 still stalled", 64'(inReady), 64'd0);
    @(posedge clk); #1;
    inValid  = 1'b0;
    outReady = 1'b1;
    settle();
    check("R9 released once", 64'(capN - base), 64'd1);
    sendVtx(16'h604); sendVtx(16'h605);
    settle();
    check("R9 stalled vertex not taken", 64'(capN - base), 64'd1);
    sendVtx(16'h606);
    settle();
    expTri("R9 next group", base + 1, 16'h604, 16'h605, 16'h606);
  endtask

  task automatic testClearStall();
    @(posedge clk); #1;
    inValid = 1'b1;
    inVertex = 16'h700;
    restart = 1'b1;
    @(negedge clk);
    check("R10 restart stalls", 64'(inReady), 64'd0);
    @(posedge clk); #1;
    restart  = 1'b0;
    cfgValid = 1'b1;
    cfgTopo  = 2'd0;
    @(negedge clk);
    check("R10 cfg stalls", 64'(inReady), 64'd0);
    @(posedge clk); #1;
    cfgValid = 1'b0;
    inValid  = 1'b0;
    @(negedge clk);
    check("R10 ready after", 64'(inReady), 64'd1);
  endtask

  initial begin
    outReady = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testList(0, "R2");
    testList(3, "R3");
    testStrip();
    testFan();
    testCfgClear();
    testRestart();
    testBackpressure();
    testClearStall();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule